// File: doc/BRIEF.md
# Double-Buffered Info Packet Store

This block keeps up to fifteen generic info packets for a display transmitter, which sends them during blanking. Each packet slot is nine 32-bit words: a header word holding four header bytes, then eight payload words. Software reaches the store through a small register port. It writes a word pointer through the index register, then streams words through the data register, and the pointer steps forward by one after each stored word. A slot's first word is at word address slot × 9.

Every slot has two copies. Software writes only the staging copy. The transmitter reads only the active copy, through a registered read port. To publish a slot, software sets that slot's bit in the update register. A small commit machine waits for a block-update strobe that arrives while the block-update lock is low. On that strobe it captures the pending set, and on the following edge it copies every captured slot in one step. The pending bits of those slots clear on the same edge, so software can poll them to see that the transfer is done.

A sticky conflict flag catches a software data write that lands in the same slot the transmitter is reading in that cycle. Writing 1 to bit 0 of the status register clears the flag. The commit machine has three states. CM_IDLE means nothing is pending. CM_ARMED means requests are pending and it is waiting for a strobe. CM_COMMIT is the single copy cycle. The transitions are IDLE→ARMED when a bit is pending, IDLE/ARMED→COMMIT on a strobe sampled with the lock low and at least one bit pending, and COMMIT→IDLE always.

Top module: `ipkt_dbuf_store`

## Requirements
- R1: After reset the word pointer is 0, all update bits are 0, the conflict flag is 0, and every active word reads as 0.
- R2: A register write with `reg_sel`=0 loads the word pointer from `reg_wr_data[7:0]`. A write with `reg_sel`=1 stores `reg_wr_data` into the staging word at the pointer and increments the pointer by one. Both take effect on that clock edge.
- R3: A data write while the pointer is 135 or more stores nothing, and the pointer keeps its value.
- R4: Staging writes are not visible on the read port until that slot is committed.
- R5: A write with `reg_sel`=2 ORs `reg_wr_data[14:0]` into the update bits (bit n is slot n). Bits 31:15 of that write are ignored.
- R6: A strobe on `blk_update`, sampled with `blk_lock` low while any update bit is set, copies all nine staging words of every pending slot into the active copy. The copy happens on the following clock edge, and the same edge clears those update bits.
- R7: A strobe sampled with `blk_lock` high copies nothing and leaves the update bits unchanged.
- R8: A commit leaves the active words of slots without a pending bit unchanged.
- R9: With `rd_en` high at an edge, `rd_data` presents the active word at `rd_addr` from that edge on. For addresses of 135 or more it presents 0. While `rd_en` is low, `rd_data` holds its value.
- R10: A data write with a valid pointer, made in the same cycle that `rd_en` reads a valid address in the same slot (address ÷ 9), sets `conflict` on that edge. A write with `reg_sel`=3 and bit 0 set clears it.
- R11: The commit takes two edges. On the strobe edge the machine enters CM_COMMIT and the update bits are still set. On the next edge the copy is made and the bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 data, 2 update, 3 status |
| reg_wr_data | input | 32 | Register write data |
| wr_ptr | output | 8 | Current word pointer |
| upd_pending | output | 15 | Per-slot update request bits |
| conflict | output | 1 | Sticky write/read collision flag |
| blk_update | input | 1 | Block-update strobe from timing |
| blk_lock | input | 1 | Block-update lock; high blocks commits |
| rd_en | input | 1 | Transmitter read enable |
| rd_addr | input | 8 | Transmitter word address |
| rd_data | output | 32 | Active word, registered |

## Verification
The hardest situation to reach is the conflict. It needs a data write and a transmitter read landing in the same slot in the same cycle, while their word addresses differ. The bench drives both in one task within a single cycle, first on the same slot and then on different slots. The lock and timing windows of the commit are also hard to hit, so the bench issues strobes with the lock high and with it low. It samples the update bits between the strobe edge and the copy edge, which shows the intermediate CM_COMMIT cycle.

// File: rtl/ipkt_pkg.sv
package ipkt_pkg;
    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_ARMED  = 2'd1,
        CM_COMMIT = 2'd2
    } cm_state_e;

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_UPDATE = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ipkt_wr_port.sv
module ipkt_wr_port
    import ipkt_pkg::*;
#(
    parameter int unsigned NSLOT = 15,
    parameter int unsigned WPS   = 9,
    parameter int unsigned DW    = 32,
    localparam int unsigned NWORDS = NSLOT * WPS,
    localparam int unsigned PTR_W  = $clog2(NWORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [DW-1:0]    reg_wr_data,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    input  logic [NSLOT-1:0] commit_clr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             stg_we,
    output logic [PTR_W-1:0] stg_addr,
    output logic [DW-1:0]    stg_data,
    output logic [NSLOT-1:0] pending,
    output logic             conflict
);
    logic [PTR_W-1:0] ptr_q;
    logic [NSLOT-1:0] pend_q;
    logic             conf_q;
    logic             idx_wr, data_wr, upd_wr, stat_wr;
    logic             ptr_ok, rd_ok, same_slot;
    logic [NSLOT-1:0] set_bits;

    always_comb begin
        idx_wr    = reg_wr_en && (reg_sel == SEL_INDEX);
        data_wr   = reg_wr_en && (reg_sel == SEL_DATA);
        upd_wr    = reg_wr_en && (reg_sel == SEL_UPDATE);
        stat_wr   = reg_wr_en && (reg_sel == SEL_STATUS);
        ptr_ok    = (32'(ptr_q) < NWORDS);
        rd_ok     = (32'(rd_addr) < NWORDS);
        same_slot = ((32'(ptr_q) / WPS) == (32'(rd_addr) / WPS));
        set_bits  = upd_wr ? reg_wr_data[NSLOT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            pend_q <= '0;
            conf_q <= 1'b0;
        end else begin
            if (idx_wr) begin
                ptr_q <= reg_wr_data[PTR_W-1:0];
            end else if (data_wr && ptr_ok) begin
                ptr_q <= ptr_q + 1'b1;
            end
            pend_q <= (pend_q & ~commit_clr) | set_bits;
            if (data_wr && ptr_ok && rd_en && rd_ok && same_slot) begin
                conf_q <= 1'b1;
            end else if (stat_wr && reg_wr_data[0]) begin
                conf_q <= 1'b0;
            end
        end
    end

    assign wr_ptr   = ptr_q;
    assign stg_we   = data_wr && ptr_ok;
    assign stg_addr = ptr_q;
    assign stg_data = reg_wr_data;
    assign pending  = pend_q;
    assign conflict = conf_q;
endmodule

// File: rtl/ipkt_commit_fsm.sv
module ipkt_commit_fsm
    import ipkt_pkg::*;
#(
    parameter int unsigned NSLOT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_update,
    input  logic             blk_lock,
    input  logic [NSLOT-1:0] pending,
    output logic [NSLOT-1:0] commit_en,
    output cm_state_e        state
);
    cm_state_e        state_q, state_d;
    logic [NSLOT-1:0] mask_q;
    logic             fire;

    assign fire = blk_update && !blk_lock && (|pending);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CM_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != CM_COMMIT && fire) begin
                mask_q <= pending;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE: begin
                if (fire)           state_d = CM_COMMIT;
                else if (|pending)  state_d = CM_ARMED;
            end
            CM_ARMED: begin
                if (fire)           state_d = CM_COMMIT;
                else if (!(|pending)) state_d = CM_IDLE;
            end
            CM_COMMIT: state_d = CM_IDLE;
            default:   state_d = CM_IDLE;
        endcase
    end

    always_comb begin
        commit_en = (state_q == CM_COMMIT) ? mask_q : '0;
        state     = state_q;
    end
endmodule

// File: rtl/ipkt_store.sv
module ipkt_store #(
    parameter int unsigned NSLOT = 15,
    parameter int unsigned WPS   = 9,
    parameter int unsigned DW    = 32,
    localparam int unsigned NWORDS = NSLOT * WPS,
    localparam int unsigned PTR_W  = $clog2(NWORDS + 1),
    localparam int unsigned OFF_W  = (WPS > 1) ? $clog2(WPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stg_we,
    input  logic [PTR_W-1:0] stg_addr,
    input  logic [DW-1:0]    stg_data,
    input  logic [NSLOT-1:0] commit_en,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] act_flat [NWORDS];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int unsigned BASE = s * WPS;
        logic [DW-1:0] stg_q [WPS];
        logic [DW-1:0] act_q [WPS];
        logic          hit;
        logic [OFF_W-1:0] off;
        logic [PTR_W-1:0] rel;

        always_comb begin
            hit = stg_we && (32'(stg_addr) >= BASE) && (32'(stg_addr) < BASE + WPS);
            rel = stg_addr - PTR_W'(BASE);
            off = rel[OFF_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < WPS; w++) begin
                    stg_q[w] <= '0;
                    act_q[w] <= '0;
                end
            end else begin
                for (int w = 0; w < WPS; w++) begin
                    if (hit && (32'(off) == w)) stg_q[w] <= stg_data;
                    if (commit_en[s])           act_q[w] <= stg_q[w];
                end
            end
        end

        for (genvar w = 0; w < WPS; w++) begin : g_word
            assign act_flat[BASE + w] = act_q[w];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= (32'(rd_addr) < NWORDS) ? act_flat[rd_addr] : '0;
        end
    end
endmodule

// File: rtl/ipkt_dbuf_store.sv
module ipkt_dbuf_store
    import ipkt_pkg::*;
#(
    parameter int unsigned NSLOT = 15,
    parameter int unsigned WPS   = 9,
    parameter int unsigned DW    = 32,
    localparam int unsigned NWORDS = NSLOT * WPS,
    localparam int unsigned PTR_W  = $clog2(NWORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [DW-1:0]    reg_wr_data,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [NSLOT-1:0] upd_pending,
    output logic             conflict,
    input  logic             blk_update,
    input  logic             blk_lock,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_data
);
    logic             stg_we;
    logic [PTR_W-1:0] stg_addr;
    logic [DW-1:0]    stg_data;
    logic [NSLOT-1:0] commit_en;
    cm_state_e        cm_state;

    ipkt_wr_port #(.NSLOT(NSLOT), .WPS(WPS), .DW(DW)) wr_port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_sel     (reg_sel),
        .reg_wr_data (reg_wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .commit_clr  (commit_en),
        .wr_ptr      (wr_ptr),
        .stg_we      (stg_we),
        .stg_addr    (stg_addr),
        .stg_data    (stg_data),
        .pending     (upd_pending),
        .conflict    (conflict)
    );

    ipkt_commit_fsm #(.NSLOT(NSLOT)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_update (blk_update),
        .blk_lock   (blk_lock),
        .pending    (upd_pending),
        .commit_en  (commit_en),
        .state      (cm_state)
    );

    ipkt_store #(.NSLOT(NSLOT), .WPS(WPS), .DW(DW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_we    (stg_we),
        .stg_addr  (stg_addr),
        .stg_data  (stg_data),
        .commit_en (commit_en),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/ipkt_dbuf_store_chk.sv
module ipkt_dbuf_store_chk #(
    parameter int unsigned NSLOT = 15,
    parameter int unsigned WPS   = 9,
    parameter int unsigned DW    = 32,
    localparam int unsigned NWORDS = NSLOT * WPS,
    localparam int unsigned PTR_W  = $clog2(NWORDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_sel,
    input logic [DW-1:0]    reg_wr_data,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [NSLOT-1:0] upd_pending,
    input logic             conflict,
    input logic             blk_update,
    input logic             blk_lock,
    input logic             rd_en,
    input logic [PTR_W-1:0] rd_addr,
    input logic [DW-1:0]    rd_data
);
    // R2: a data write with a valid pointer advances it by one
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel == 2'd1 && 32'(wr_ptr) < NWORDS)
        |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    // R3: a data write with an invalid pointer leaves it alone
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel == 2'd1 && 32'(wr_ptr) >= NWORDS)
        |=> $stable(wr_ptr));

    // R7: update bits clear only two edges after an unlocked strobe
    p_no_clear_wo_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(blk_update && !blk_lock, 2)
        |-> ((upd_pending & $past(upd_pending)) == $past(upd_pending)));

    // R9: read data holds without a read
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9: out-of-range reads give zero
    p_rd_oor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(rd_addr) >= NWORDS) |=> (rd_data == '0));

    // R10: same-slot collision raises the flag
    p_conflict_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel == 2'd1 && 32'(wr_ptr) < NWORDS && rd_en &&
         32'(rd_addr) < NWORDS && (32'(wr_ptr) / WPS) == (32'(rd_addr) / WPS))
        |=> conflict);
endmodule

bind ipkt_dbuf_store ipkt_dbuf_store_chk #(.NSLOT(NSLOT), .WPS(WPS), .DW(DW)) chk_i (.*);

// File: tb/ipkt_dbuf_store_tb.sv
module ipkt_dbuf_store_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT  = 15;
    localparam int WPS    = 9;
    localparam int NWORDS = NSLOT * WPS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  wr_ptr;
    logic [14:0] upd_pending;
    logic        conflict;
    logic        blk_update = 1'b0;
    logic        blk_lock = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] m_stg [NWORDS];
    logic [31:0] m_act [NWORDS];
    int          m_ptr;
    logic [14:0] m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipkt_dbuf_store dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wr_data(reg_wr_data), .wr_ptr(wr_ptr), .upd_pending(upd_pending),
        .conflict(conflict), .blk_update(blk_update), .blk_lock(blk_lock),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel == 2'd0) m_ptr = int'(d[7:0]);
        if (sel == 2'd1 && m_ptr < NWORDS) begin
            m_stg[m_ptr] = d;
            m_ptr++;
        end
        if (sel == 2'd2) m_pend |= d[14:0];
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic strobe(input logic lock, input string req);
        @(negedge clk);
        blk_update = 1'b1; blk_lock = lock;
        @(negedge clk);
        blk_update = 1'b0; blk_lock = 1'b0;
        // R11: after the strobe edge the bits are still set
        check(req, 32'(upd_pending), 32'(m_pend));
        @(negedge clk);
        if (!lock) begin
            for (int s = 0; s < NSLOT; s++)
                if (m_pend[s])
                    for (int w = 0; w < WPS; w++) m_act[s*WPS+w] = m_stg[s*WPS+w];
            m_pend = '0;
        end
    endtask

    task automatic fill_slot(input int s, input logic [31:0] seed);
        wr(2'd0, 32'(s * WPS));
        for (int w = 0; w < WPS; w++) wr(2'd1, seed + 32'(w * 32'h0101_0101));
    endtask

    task automatic check_slot(input int s, input string req);
        logic [31:0] v;
        for (int w = 0; w < WPS; w++) begin
            rd(s * WPS + w, v);
            check(req, v, m_act[s*WPS+w]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 ptr", 32'(wr_ptr), 0);
        check("R1 pending", 32'(upd_pending), 0);
        check("R1 conflict", 32'(conflict), 0);
        rd(0, v);   check("R1 word0", v, 0);
        rd(134, v); check("R1 word134", v, 0);
    endtask

    task automatic t_fill_commit;
        logic [31:0] v;
        fill_slot(3, 32'hD4C3_B2A1);
        check("R2 ptr", 32'(wr_ptr), 36);
        rd(27, v); check("R4 hidden", v, 0);
        wr(2'd2, 32'h0000_0008);
        check("R5 set", 32'(upd_pending), 32'h8);
        strobe(1'b0, "R11 commit cycle");
        check("R6 cleared", 32'(upd_pending), 0);
        check_slot(3, "R6 copy");
    endtask

    task automatic t_lock;
        logic [31:0] v;
        fill_slot(5, 32'h1111_0000);
        wr(2'd2, 32'h0000_0020);
        strobe(1'b1, "R7 lock pending");
        check("R7 still pending", 32'(upd_pending), 32'h20);
        rd(45, v); check("R7 no copy", v, 0);
        strobe(1'b0, "R11 commit cycle");
        check_slot(5, "R6 after unlock");
    endtask

    task automatic t_partial;
        fill_slot(0, 32'hAAAA_0000);
        fill_slot(1, 32'h5555_0000);
        wr(2'd2, 32'h0000_0002);
        strobe(1'b0, "R11 commit cycle");
        check_slot(0, "R8 untouched");
        check_slot(1, "R6 slot1");
    endtask

    task automatic t_invalid;
        logic [31:0] v;
        wr(2'd0, 32'd135);
        wr(2'd1, 32'hDEAD_BEEF);
        check("R3 ptr hold 135", 32'(wr_ptr), 135);
        wr(2'd0, 32'd200);
        wr(2'd1, 32'hDEAD_BEEF);
        check("R3 ptr hold 200", 32'(wr_ptr), 200);
        wr(2'd2, 32'hFFFF_8000);
        check("R5 high bits ignored", 32'(upd_pending), 0);
        wr(2'd2, 32'h0000_4000);
        strobe(1'b0, "R11 commit cycle");
        rd(134, v); check("R3 no stray write", v, 0);
    endtask

    task automatic t_read;
        logic [31:0] v;
        rd(28, v); check("R9 read", v, m_act[28]);
        repeat (3) @(negedge clk);
        check("R9 hold", rd_data, m_act[28]);
        rd(140, v); check("R9 out of range", v, 0);
    endtask

    task automatic t_conflict;
        wr(2'd0, 32'd18);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wr_data = 32'h0BAD_F00D;
        rd_en = 1'b1; rd_addr = 8'd20;
        @(negedge clk);
        reg_wr_en = 1'b0; rd_en = 1'b0;
        m_stg[18] = 32'h0BAD_F00D; m_ptr = 19;
        check("R10 set", 32'(conflict), 1);
        wr(2'd3, 32'h1);
        check("R10 clear", 32'(conflict), 0);
        wr(2'd0, 32'd0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wr_data = 32'h1234_5678;
        rd_en = 1'b1; rd_addr = 8'd20;
        @(negedge clk);
        reg_wr_en = 1'b0; rd_en = 1'b0;
        check("R10 other slot", 32'(conflict), 0);
    endtask

    initial begin
        for (int i = 0; i < NWORDS; i++) begin m_stg[i] = '0; m_act[i] = '0; end
        m_ptr = 0; m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_commit();
        t_lock();
        t_partial();
        t_invalid();
        t_read();
        t_conflict();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule